// File: doc/BRIEF.md
# ECC Error Event Logger

This block sits on a sideband next to a memory module's error-correction logic and keeps a record of every error event it is told about. Two event channels can each report one event per clock. An event says whether the on-die or the module-level corrector saw it, whether it was a corrected single-bit error or an uncorrectable multi-bit detection, and which rank, bank and region it hit. The block stamps each event with the value of a free-running time input in the cycle the event arrives and pushes the record into a 16-entry queue. The block has no data inputs, so no record can hold a data word.

Alongside the queue it keeps a count of all events received, a saturating count of events lost because the queue was full, and one saturating frequency counter per region. A region counter counts corrected events only. A host reads all of this through a small request/acknowledge register port. Reading the record-info word removes the head record from the queue. A separate clear strobe zeroes the region counters.

The read port is a two-state machine. `RP_IDLE` waits for `rd_req` and latches `rd_addr`. The transition `IDLE->RESP` happens on a request. `RP_RESP` drives `rd_ack` and `rd_data` for one cycle and pops the queue when the info word of a non-empty queue is read. The transition `RESP->IDLE` is unconditional.

Top module: `ecc_evt_log`

## Requirements
- R1: An event present on a channel at a clock edge is stored with the `time_now` value of that cycle. Records leave the queue in arrival order. Address 0 returns the head record's time (0 when empty).
- R2: Address 1 returns the head record's info word: bits [1:0] rank, [6:2] bank, [10:7] region, bit 11 source (0 on-die, 1 module), bit 12 severity (0 corrected, 1 uncorrectable), bit 31 valid. All other bits are 0.
- R3: When both channels report in one cycle, an uncorrectable event is queued before a corrected one. At equal severity, channel 0 is queued first.
- R4: Reading address 1 pops the head record when the queue is not empty. Reading it on an empty queue returns 0 with bit 31 clear and changes nothing. Address 4 returns the queue level. Other reads do not pop.
- R5: When the queue holds 16 records, new events are discarded. Address 3 is a 16-bit saturating count of discarded events. If only one slot is free for two events, the one ordered first by R3 is kept.
- R6: Address 32+r returns a 16-bit saturating count of corrected events in region r. Uncorrectable events are not counted. Two matching events in one cycle add 2.
- R7: A one-cycle pulse on `clr_region_cnt` zeroes every region counter. It leaves the queue, the total count and the discard count unchanged.
- R8: Address 2 returns the number of events received on both channels, whether queued or discarded.
- R9: After reset the queue is empty and every counter reads 0.
- R10: `rd_ack` rises in the cycle after the edge that samples `rd_req` and lasts exactly one cycle. A request held high during that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 32 | Monotonic time value sampled on events |
| ev0_valid | input | 1 | Channel 0 event strobe |
| ev0_src | input | 1 | Channel 0 source: 0 on-die, 1 module |
| ev0_sev | input | 1 | Channel 0 severity: 0 corrected, 1 uncorrectable |
| ev0_rank | input | 2 | Channel 0 rank |
| ev0_bank | input | 5 | Channel 0 bank |
| ev0_region | input | 4 | Channel 0 region |
| ev1_valid | input | 1 | Channel 1 event strobe |
| ev1_src | input | 1 | Channel 1 source |
| ev1_sev | input | 1 | Channel 1 severity |
| ev1_rank | input | 2 | Channel 1 rank |
| ev1_bank | input | 5 | Channel 1 bank |
| ev1_region | input | 4 | Channel 1 region |
| clr_region_cnt | input | 1 | Clear all region counters |
| rd_req | input | 1 | Register read request |
| rd_addr | input | 6 | Register read address |
| rd_ack | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
The bench drives single events on one channel to check time stamping and field placement. It drives mixed-severity pairs in both channel orders to tell the severity priority apart from a fixed channel priority. It drives equal-severity pairs to show the channel tie-break. Filling the queue and then sending a pair with one slot free separates "drop both" from "keep the first in order". A long run of paired corrected events in one region checks that the counters saturate instead of wrapping and that the total still counts every event. Reads on an empty queue and held requests separate a real pop from a spurious one.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    localparam int TIME_W   = 32;
    localparam int RANK_W   = 2;
    localparam int BANK_W   = 5;
    localparam int REGION_W = 4;
    localparam int NREG     = 1 << REGION_W;

    // Event attributes; no data contents are carried anywhere.
    typedef struct packed {
        logic                sev;     // 0 corrected, 1 uncorrectable
        logic                src;     // 0 on-die, 1 module level
        logic [REGION_W-1:0] region;
        logic [BANK_W-1:0]   bank;
        logic [RANK_W-1:0]   rank;
    } evt_t;

    localparam int EVT_W = $bits(evt_t);

    typedef struct packed {
        logic [TIME_W-1:0] stamp;
        evt_t              ev;
    } rec_t;

    typedef enum logic [0:0] {
        RP_IDLE = 1'b0,
        RP_RESP = 1'b1
    } rp_state_e;

    localparam logic [5:0] ADDR_TIME  = 6'd0;
    localparam logic [5:0] ADDR_INFO  = 6'd1;
    localparam logic [5:0] ADDR_TOTAL = 6'd2;
    localparam logic [5:0] ADDR_DROP  = 6'd3;
    localparam logic [5:0] ADDR_LEVEL = 6'd4;

    function automatic logic [31:0] info_word(input evt_t e, input logic v);
        return {v, {(31-EVT_W){1'b0}}, e};
    endfunction

endpackage

// File: rtl/ecc_evt_order.sv
module ecc_evt_order
    import ecc_log_pkg::*;
(
    input  logic              v0,
    input  evt_t              e0,
    input  logic              v1,
    input  evt_t              e1,
    input  logic [TIME_W-1:0] stamp,
    output logic              first_v,
    output rec_t              first,
    output logic              second_v,
    output rec_t              second
);

    logic swap;

    // Channel 1 goes first only when it alone is uncorrectable.
    assign swap = v0 && v1 && e1.sev && !e0.sev;

    always_comb begin
        first_v  = 1'b0;
        second_v = 1'b0;
        first    = '{stamp: stamp, ev: e0};
        second   = '{stamp: stamp, ev: e1};
        if (!v0) begin
            first_v = v1;
            first   = '{stamp: stamp, ev: e1};
        end else if (swap) begin
            first_v  = 1'b1;
            second_v = 1'b1;
            first    = '{stamp: stamp, ev: e1};
            second   = '{stamp: stamp, ev: e0};
        end else begin
            first_v  = 1'b1;
            second_v = v1;
        end
    end

endmodule

// File: rtl/ecc_evt_fifo.sv
module ecc_evt_fifo
    import ecc_log_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     a_v,
    input  rec_t                     a_rec,
    input  logic                     b_v,
    input  rec_t                     b_rec,
    input  logic                     pop,
    output logic                     a_acc,
    output logic                     b_acc,
    output rec_t                     head,
    output logic [$clog2(DEPTH):0]   level
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = PTR_W + 1;

    rec_t             mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [LVL_W-1:0] cnt_q;
    logic             do_pop;
    logic [PTR_W-1:0] b_slot;

    // Free space is judged on the level before any same-cycle pop.
    always_comb begin
        a_acc  = a_v && (cnt_q < LVL_W'(DEPTH));
        b_acc  = b_v && ((cnt_q + LVL_W'(a_acc)) < LVL_W'(DEPTH));
        do_pop = pop && (cnt_q != '0);
        b_slot = wptr_q + PTR_W'(a_acc);
    end

    always_ff @(posedge clk) begin
        if (a_acc) mem[wptr_q] <= a_rec;
        if (b_acc) mem[b_slot] <= b_rec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            wptr_q <= wptr_q + PTR_W'(a_acc) + PTR_W'(b_acc);
            rptr_q <= rptr_q + PTR_W'(do_pop);
            cnt_q  <= cnt_q + LVL_W'(a_acc) + LVL_W'(b_acc) - LVL_W'(do_pop);
        end
    end

    assign head  = mem[rptr_q];
    assign level = cnt_q;

endmodule

// File: rtl/ecc_region_cnt.sv
module ecc_region_cnt
    import ecc_log_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           a_hit,
    input  logic [REGION_W-1:0]            a_region,
    input  logic                           b_hit,
    input  logic [REGION_W-1:0]            b_region,
    output logic [NREG-1:0][CNT_W-1:0]     cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [1:0]       inc;
        logic [CNT_W:0]   sum;
        logic [CNT_W-1:0] cnt_q;

        always_comb begin
            inc = 2'(a_hit && (a_region == REGION_W'(r)))
                + 2'(b_hit && (b_region == REGION_W'(r)));
            sum = {1'b0, cnt_q} + (CNT_W+1)'(inc);
        end

        always_ff @(posedge clk) begin
            if (!rst_n)        cnt_q <= '0;
            else if (clr)      cnt_q <= CNT_W'(inc);
            else if (sum[CNT_W]) cnt_q <= CNT_MAX;
            else               cnt_q <= sum[CNT_W-1:0];
        end

        assign cnt[r] = cnt_q;
    end

endmodule

// File: rtl/ecc_evt_log.sv
module ecc_evt_log
    import ecc_log_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 16,
    parameter int DROP_W = 16,
    parameter int TOT_W  = 32,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TIME_W-1:0]   time_now,
    input  logic                ev0_valid,
    input  logic                ev0_src,
    input  logic                ev0_sev,
    input  logic [RANK_W-1:0]   ev0_rank,
    input  logic [BANK_W-1:0]   ev0_bank,
    input  logic [REGION_W-1:0] ev0_region,
    input  logic                ev1_valid,
    input  logic                ev1_src,
    input  logic                ev1_sev,
    input  logic [RANK_W-1:0]   ev1_rank,
    input  logic [BANK_W-1:0]   ev1_bank,
    input  logic [REGION_W-1:0] ev1_region,
    input  logic                clr_region_cnt,
    input  logic                rd_req,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic                rd_ack,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int LVL_W = $clog2(DEPTH) + 1;
    localparam logic [ADDR_W-1:0] REGION_BASE = ADDR_W'(1 << (ADDR_W - 1));
    localparam logic [TOT_W-1:0]  TOT_MAX  = '1;
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    evt_t             e0, e1;
    logic             first_v, second_v;
    rec_t             first, second;
    logic             a_acc, b_acc;
    rec_t             head;
    logic [LVL_W-1:0] lvl;
    logic             pop;
    logic [NREG-1:0][CNT_W-1:0] reg_cnt;

    rp_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [TOT_W-1:0] total_q;
    logic [DROP_W-1:0] drop_q;
    logic [1:0]       n_evt, n_drop;
    logic [TOT_W:0]   total_sum;
    logic [DROP_W:0]  drop_sum;

    assign e0 = '{sev: ev0_sev, src: ev0_src, region: ev0_region, bank: ev0_bank, rank: ev0_rank};
    assign e1 = '{sev: ev1_sev, src: ev1_src, region: ev1_region, bank: ev1_bank, rank: ev1_rank};

    ecc_evt_order u_order (
        .v0       (ev0_valid),
        .e0       (e0),
        .v1       (ev1_valid),
        .e1       (e1),
        .stamp    (time_now),
        .first_v  (first_v),
        .first    (first),
        .second_v (second_v),
        .second   (second)
    );

    ecc_evt_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .a_v   (first_v),
        .a_rec (first),
        .b_v   (second_v),
        .b_rec (second),
        .pop   (pop),
        .a_acc (a_acc),
        .b_acc (b_acc),
        .head  (head),
        .level (lvl)
    );

    ecc_region_cnt #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_region_cnt),
        .a_hit    (ev0_valid && !ev0_sev),
        .a_region (ev0_region),
        .b_hit    (ev1_valid && !ev1_sev),
        .b_region (ev1_region),
        .cnt      (reg_cnt)
    );

    // Event and discard counters
    always_comb begin
        n_evt     = 2'(ev0_valid) + 2'(ev1_valid);
        n_drop    = 2'(first_v && !a_acc) + 2'(second_v && !b_acc);
        total_sum = {1'b0, total_q} + (TOT_W+1)'(n_evt);
        drop_sum  = {1'b0, drop_q} + (DROP_W+1)'(n_drop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
            drop_q  <= '0;
        end else begin
            total_q <= total_sum[TOT_W]  ? TOT_MAX  : total_sum[TOT_W-1:0];
            drop_q  <= drop_sum[DROP_W]  ? DROP_MAX : drop_sum[DROP_W-1:0];
        end
    end

    // Read port: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                           addr_q <= '0;
        else if (state_q == RP_IDLE && rd_req) addr_q <= rd_addr;
    end

    // Read port: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE: if (rd_req) state_d = RP_RESP;
            RP_RESP: state_d = RP_IDLE;
        endcase
    end

    // Read port: outputs
    always_comb begin
        rd_ack  = 1'b0;
        rd_data = '0;
        pop     = 1'b0;
        unique case (state_q)
            RP_IDLE: ;
            RP_RESP: begin
                rd_ack = 1'b1;
                if (addr_q == ADDR_W'(ADDR_TIME)) begin
                    if (lvl != '0) rd_data = DATA_W'(head.stamp);
                end else if (addr_q == ADDR_W'(ADDR_INFO)) begin
                    if (lvl != '0) begin
                        rd_data = DATA_W'(info_word(head.ev, 1'b1));
                        pop     = 1'b1;
                    end
                end else if (addr_q == ADDR_W'(ADDR_TOTAL)) begin
                    rd_data = DATA_W'(total_q);
                end else if (addr_q == ADDR_W'(ADDR_DROP)) begin
                    rd_data = DATA_W'(drop_q);
                end else if (addr_q == ADDR_W'(ADDR_LEVEL)) begin
                    rd_data = DATA_W'(lvl);
                end else if (addr_q >= REGION_BASE
                             && (addr_q - REGION_BASE) < ADDR_W'(NREG)) begin
                    rd_data = DATA_W'(reg_cnt[addr_q[REGION_W-1:0]]);
                end
            end
        endcase
    end

endmodule

// File: rtl/ecc_evt_log_chk.sv
module ecc_evt_log_chk #(
    parameter int DEPTH  = 16,
    parameter int LVL_W  = 5,
    parameter int CNT_W  = 16,
    parameter int DROP_W = 16,
    parameter int TOT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_ack,
    input logic              clr_region_cnt,
    input logic [LVL_W-1:0]  level,
    input logic [TOT_W-1:0]  total,
    input logic [DROP_W-1:0] dropped,
    input logic [CNT_W-1:0]  reg0
);

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R10
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !rd_ack);

    // R10
    ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> $past(rd_req));

    // R5
    drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dropped >= $past(dropped));

    // R8
    total_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        total >= $past(total));

    // R6
    region_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_region_cnt |=> reg0 >= $past(reg0));

    // R7
    region_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_region_cnt |=> reg0 <= CNT_W'(2));

endmodule

bind ecc_evt_log ecc_evt_log_chk #(
    .DEPTH  (DEPTH),
    .LVL_W  ($clog2(DEPTH) + 1),
    .CNT_W  (CNT_W),
    .DROP_W (DROP_W),
    .TOT_W  (TOT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_req         (rd_req),
    .rd_ack         (rd_ack),
    .clr_region_cnt (clr_region_cnt),
    .level          (lvl),
    .total          (total_q),
    .dropped        (drop_q),
    .reg0           (reg_cnt[0])
);

// File: tb/ecc_evt_log_test.sv
module ecc_evt_log_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] time_now = '0;
    logic        ev0_valid = 0, ev0_src = 0, ev0_sev = 0;
    logic [1:0]  ev0_rank = '0;
    logic [4:0]  ev0_bank = '0;
    logic [3:0]  ev0_region = '0;
    logic        ev1_valid = 0, ev1_src = 0, ev1_sev = 0;
    logic [1:0]  ev1_rank = '0;
    logic [4:0]  ev1_bank = '0;
    logic [3:0]  ev1_region = '0;
    logic        clr_region_cnt = 0;
    logic        rd_req = 0;
    logic [5:0]  rd_addr = '0;
    logic        rd_ack;
    logic [31:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int tot_exp = 0;

    localparam logic [5:0] A_TIME = 6'd0, A_INFO = 6'd1, A_TOTAL = 6'd2,
                           A_DROP = 6'd3, A_LEVEL = 6'd4, A_REG = 6'd32;

    always #5 clk = ~clk;

    ecc_evt_log uut (
        .clk(clk), .rst_n(rst_n), .time_now(time_now),
        .ev0_valid(ev0_valid), .ev0_src(ev0_src), .ev0_sev(ev0_sev),
        .ev0_rank(ev0_rank), .ev0_bank(ev0_bank), .ev0_region(ev0_region),
        .ev1_valid(ev1_valid), .ev1_src(ev1_src), .ev1_sev(ev1_sev),
        .ev1_rank(ev1_rank), .ev1_bank(ev1_bank), .ev1_region(ev1_region),
        .clr_region_cnt(clr_region_cnt), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] info(input logic sev, input logic src,
        input logic [3:0] rg, input logic [4:0] bk, input logic [1:0] rk);
        return {1'b1, 18'b0, sev, src, rg, bk, rk};
    endfunction

    // Called at a negedge; returns at a later negedge.
    task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
        rd_req  = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        if (rd_ack !== 1'b1) begin
            errors++; checks++;
            $display("FAIL R10: rd_ack got %b expected 1", rd_ack);
        end
        d = rd_data;
        @(negedge clk);
    endtask

    task automatic set0(input logic src, input logic sev, input logic [1:0] rk,
                        input logic [4:0] bk, input logic [3:0] rg);
        ev0_valid = 1; ev0_src = src; ev0_sev = sev;
        ev0_rank = rk; ev0_bank = bk; ev0_region = rg;
        tot_exp++;
    endtask

    task automatic set1(input logic src, input logic sev, input logic [1:0] rk,
                        input logic [4:0] bk, input logic [3:0] rg);
        ev1_valid = 1; ev1_src = src; ev1_sev = sev;
        ev1_rank = rk; ev1_bank = bk; ev1_region = rg;
        tot_exp++;
    endtask

    task automatic tick(input logic [31:0] t);
        time_now = t;
        @(negedge clk);
        ev0_valid = 0;
        ev1_valid = 0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        reg_read(A_LEVEL, d); chk("R9 level", d, 0);
        reg_read(A_TOTAL, d); chk("R9 total", d, 0);
        reg_read(A_DROP, d);  chk("R9 dropped", d, 0);
        reg_read(A_REG + 6'd3, d); chk("R9 region3", d, 0);
        reg_read(A_INFO, d);  chk("R4 empty info", d, 0);
        reg_read(A_LEVEL, d); chk("R4 empty no pop", d, 0);
    endtask

    task automatic t_single;
        logic [31:0] d;
        set0(1'b0, 1'b0, 2'd2, 5'd17, 4'd9);
        tick(32'h1234_5678);
        time_now = 32'h0000_0099;
        reg_read(A_LEVEL, d); chk("R1 level one", d, 1);
        reg_read(A_TIME, d);  chk("R1 stamp", d, 32'h1234_5678);
        reg_read(A_LEVEL, d); chk("R4 time read no pop", d, 1);
        reg_read(A_INFO, d);  chk("R2 info", d, info(0, 0, 4'd9, 5'd17, 2'd2));
        reg_read(A_LEVEL, d); chk("R4 pop", d, 0);
        reg_read(A_REG + 6'd9, d); chk("R6 region9", d, 1);
        set1(1'b1, 1'b1, 2'd1, 5'd4, 4'd6);
        tick(32'h0000_0200);
        reg_read(A_INFO, d);  chk("R2 info ch1 module uncorr", d, info(1, 1, 4'd6, 5'd4, 2'd1));
        reg_read(A_REG + 6'd6, d); chk("R6 uncorr not counted", d, 0);
        reg_read(A_TOTAL, d); chk("R8 total", d, 32'(tot_exp));
    endtask

    task automatic t_pairs;
        logic [31:0] d;
        // uncorrectable on channel 1 goes first
        set0(1'b1, 1'b0, 2'd0, 5'd1, 4'd2);
        set1(1'b0, 1'b1, 2'd3, 5'd2, 4'd2);
        tick(32'd300);
        // uncorrectable on channel 0 stays first
        set0(1'b0, 1'b1, 2'd1, 5'd3, 4'd4);
        set1(1'b1, 1'b0, 2'd2, 5'd5, 4'd4);
        tick(32'd301);
        // equal severity: channel 0 first
        set0(1'b0, 1'b0, 2'd1, 5'd8, 4'd2);
        set1(1'b1, 1'b0, 2'd2, 5'd9, 4'd2);
        tick(32'd302);
        reg_read(A_LEVEL, d); chk("R3 level six", d, 6);
        reg_read(A_TIME, d);  chk("R3 stamp pair", d, 300);
        reg_read(A_INFO, d);  chk("R3 uncorr ch1 first", d, info(1, 0, 4'd2, 5'd2, 2'd3));
        reg_read(A_INFO, d);  chk("R3 corr ch0 second", d, info(0, 1, 4'd2, 5'd1, 2'd0));
        reg_read(A_INFO, d);  chk("R3 uncorr ch0 first", d, info(1, 0, 4'd4, 5'd3, 2'd1));
        reg_read(A_INFO, d);  chk("R3 corr ch1 second", d, info(0, 1, 4'd4, 5'd5, 2'd2));
        reg_read(A_TIME, d);  chk("R1 stamp third pair", d, 302);
        reg_read(A_INFO, d);  chk("R3 tie ch0 first", d, info(0, 0, 4'd2, 5'd8, 2'd1));
        reg_read(A_INFO, d);  chk("R3 tie ch1 second", d, info(0, 1, 4'd2, 5'd9, 2'd2));
        reg_read(A_REG + 6'd2, d); chk("R6 two in one cycle", d, 3);
    endtask

    task automatic t_overflow;
        logic [31:0] d;
        for (int i = 0; i < 16; i++) begin
            set0(1'b0, 1'b0, 2'd0, 5'd0, 4'd1);
            tick(32'(100 + i));
        end
        reg_read(A_LEVEL, d); chk("R5 full", d, 16);
        set0(1'b0, 1'b0, 2'd0, 5'd0, 4'd1);
        set1(1'b0, 1'b1, 2'd0, 5'd0, 4'd1);
        tick(32'd500);
        reg_read(A_DROP, d);  chk("R5 both dropped", d, 2);
        reg_read(A_LEVEL, d); chk("R5 still full", d, 16);
        reg_read(A_REG + 6'd1, d); chk("R6 counts dropped", d, 17);
        reg_read(A_TIME, d);  chk("R1 oldest first", d, 100);
        reg_read(A_INFO, d);
        set0(1'b0, 1'b0, 2'd0, 5'd3, 4'd1);
        set1(1'b1, 1'b1, 2'd0, 5'd7, 4'd1);
        tick(32'd999);
        reg_read(A_DROP, d);  chk("R5 one dropped", d, 3);
        for (int i = 0; i < 15; i++) reg_read(A_INFO, d);
        reg_read(A_TIME, d);  chk("R5 kept stamp", d, 999);
        reg_read(A_INFO, d);  chk("R5 kept first ordered", d, info(1, 1, 4'd1, 5'd7, 2'd0));
        reg_read(A_LEVEL, d); chk("R4 drained", d, 0);
    endtask

    task automatic t_clear;
        logic [31:0] d;
        set0(1'b0, 1'b0, 2'd0, 5'd0, 4'd7);
        tick(32'd1000);
        clr_region_cnt = 1'b1;
        @(negedge clk);
        clr_region_cnt = 1'b0;
        reg_read(A_REG + 6'd1, d); chk("R7 region1 cleared", d, 0);
        reg_read(A_REG + 6'd2, d); chk("R7 region2 cleared", d, 0);
        reg_read(A_LEVEL, d); chk("R7 queue kept", d, 1);
        reg_read(A_DROP, d);  chk("R7 dropped kept", d, 3);
        reg_read(A_TOTAL, d); chk("R7 total kept", d, 32'(tot_exp));
        reg_read(A_INFO, d);
    endtask

    task automatic t_saturate;
        logic [31:0] d;
        for (int i = 0; i < 32800; i++) begin
            set0(1'b0, 1'b0, 2'd0, 5'd0, 4'd5);
            set1(1'b1, 1'b0, 2'd0, 5'd0, 4'd5);
            tick(32'(2000 + i));
        end
        reg_read(A_REG + 6'd5, d); chk("R6 saturate", d, 32'hFFFF);
        reg_read(A_DROP, d);  chk("R5 drop saturate", d, 32'hFFFF);
        reg_read(A_TOTAL, d); chk("R8 total long run", d, 32'(tot_exp));
        reg_read(A_LEVEL, d); chk("R5 full after run", d, 16);
    endtask

    task automatic t_ack;
        logic [31:0] d;
        rd_req = 1'b1; rd_addr = A_TOTAL;
        chk("R10 no ack same cycle", 32'(rd_ack), 0);
        @(negedge clk);
        chk("R10 ack", 32'(rd_ack), 1);
        @(negedge clk);
        chk("R10 held req ignored", 32'(rd_ack), 0);
        @(negedge clk);
        chk("R10 ack again", 32'(rd_ack), 1);
        rd_req = 1'b0;
        @(negedge clk);
        reg_read(A_LEVEL, d); chk("R10 no pop from total reads", d, 16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_single;
        t_pairs;
        t_overflow;
        t_clear;
        t_saturate;
        t_ack;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule